// File: doc/BRIEF.md
# Stateful Boolean Micro-Op Engine

This block models a small compute-in-storage array of single-bit cells. A command picks one of sixteen two-input Boolean functions, two source cells and a destination cell; the engine splits the function into a timed series of one-step primitives and writes every result back into the array. The only writes are primitives that work in one of two ways. Some clear their target to 0 and then set it to 1 when a condition holds. Others change a cell in one direction only. For this reason some functions overwrite one of their own inputs, and others go through a scratch cell.

Software loads operands with the constant functions and reads results through a single combinational read port. A command is taken on a valid/ready handshake. Busy covers the whole sequence. Done pulses once when the last step has written its result. A command whose destination or scratch use would destroy a source it still needs is refused, and an error pulse is raised.

Top module: `bool_uop_engine`

## Requirements
- R1: After reset every cell reads 0, cmd_ready_o is 1, and busy_o, done_o and err_o are 0.
- R2: rd_data_o always shows the cell chosen by rd_idx_i, in the same cycle. Reading never changes any cell.
- R3: Single-step functions by cmd_op_i code: 0 writes 0 to dst, 1 writes 1 to dst, 2 writes ~A, 3 writes ~B, 4 writes ~(A&B) and 5 writes ~(A|B), all into dst.
- R4: Two-step and three-step functions use scratch cell N_CELLS-1 (S). Code 10 does S=~A then dst=~S. Code 11 does S=~B then dst=~S. Code 12 does S=~(A&B) then dst=~S. Code 13 does S=~(A|B) then dst=~S. Code 14 does S=~(A&B), dst=~(A|B), then dst|=~S (XNOR). Code 15 does S=~(A|B), dst=~(A&B), then dst&=~S (XOR). S keeps its intermediate value afterwards.
- R5: The implication codes ignore dst and write into a source cell, in one step. Code 6 sets B|=~A. Code 7 sets A&=~B. Code 8 sets A|=~B. Code 9 sets B&=~A.
- R6: Each step lasts STEP_CYC cycles. A clearing step writes 0 to its target on its first edge and the result on its last edge. A one-direction step changes its target only on its last edge. At most one cell changes per cycle.
- R7: A command is taken when cmd_valid_i and cmd_ready_o are both high. From that edge until the final write, busy_o is 1 and cmd_ready_o is 0, and valid commands are ignored. While idle, no cell changes.
- R8: done_o is 1 for exactly the one cycle that follows the edge of the final write. In that cycle busy_o is 0.
- R9: A taken command is refused in two cases. The first is a code of 10 or higher where dst, or a source the function reads, equals S. The second is a code that writes dst (any code except 6 to 9) where dst equals a source it reads. A refused command raises err_o for one cycle, leaves busy_o at 0 and changes no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine can take a command |
| cmd_op_i | input | 4 | Function code |
| cmd_a_i | input | IW | Source A cell index |
| cmd_b_i | input | IW | Source B cell index |
| cmd_dst_i | input | IW | Destination cell index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final write |
| err_o | output | 1 | One-cycle pulse for a refused command |
| rd_idx_i | input | IW | Read cell index |
| rd_data_o | output | 1 | Value of the selected cell |

## Verification
A wrong step index or a corrupted latched command shows up on the read port as a wrong target value at the edge of the final step. A wrong intermediate in the scratch cell shows up there one step earlier. A step counter that is off by one moves the clearing edge, the result edge, the done pulse and the fall of busy_o by exactly that many cycles. The reference model compares every cycle and walks the read index over all cells, so such an error is caught within one sweep of the array.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int MAX_STEPS = 3;
  localparam int SW = 2;

  typedef enum logic [3:0] {
    OP_FALSE = 4'd0, OP_TRUE, OP_NOTA, OP_NOTB, OP_NAND, OP_NOR,
    OP_IMP, OP_NIMP, OP_RIMP, OP_RNIMP,
    OP_COPYA, OP_COPYB, OP_AND, OP_OR, OP_XNOR, OP_XOR
  } op_e;

  // CLR..NOR clear their target first; ORN/ANDN move it in one direction only
  typedef enum logic [2:0] {PK_CLR, PK_SET, PK_NOT, PK_NAND, PK_NOR, PK_ORN, PK_ANDN} prim_e;
  typedef enum logic [2:0] {SL_NONE, SL_A, SL_B, SL_S, SL_D} sel_e;

  typedef struct packed {
    prim_e kind;
    sel_e  x;
    sel_e  y;
    sel_e  t;
  } step_t;

  typedef struct packed {
    logic [SW-1:0]               last;
    step_t [MAX_STEPS-1:0]       st;
  } plan_t;

  function automatic step_t mk_step(prim_e k, sel_e x, sel_e y, sel_e t);
    step_t s;
    s.kind = k;
    s.x    = x;
    s.y    = y;
    s.t    = t;
    return s;
  endfunction

  function automatic logic presets(prim_e k);
    return (k != PK_ORN) && (k != PK_ANDN);
  endfunction
endpackage

// File: rtl/uop_decoder.sv
module uop_decoder
  import uop_pkg::*;
(
  input  logic [3:0] op_i,
  output plan_t      plan_o,
  output logic       rd_a_o,
  output logic       rd_b_o,
  output logic       wr_d_o,
  output logic       use_s_o
);
  always_comb begin
    plan_o = '0;
    case (op_e'(op_i))
      OP_FALSE: plan_o.st[0] = mk_step(PK_CLR,  SL_NONE, SL_NONE, SL_D);
      OP_TRUE:  plan_o.st[0] = mk_step(PK_SET,  SL_NONE, SL_NONE, SL_D);
      OP_NOTA:  plan_o.st[0] = mk_step(PK_NOT,  SL_A,    SL_NONE, SL_D);
      OP_NOTB:  plan_o.st[0] = mk_step(PK_NOT,  SL_B,    SL_NONE, SL_D);
      OP_NAND:  plan_o.st[0] = mk_step(PK_NAND, SL_A,    SL_B,    SL_D);
      OP_NOR:   plan_o.st[0] = mk_step(PK_NOR,  SL_A,    SL_B,    SL_D);
      OP_IMP:   plan_o.st[0] = mk_step(PK_ORN,  SL_A,    SL_NONE, SL_B);
      OP_NIMP:  plan_o.st[0] = mk_step(PK_ANDN, SL_B,    SL_NONE, SL_A);
      OP_RIMP:  plan_o.st[0] = mk_step(PK_ORN,  SL_B,    SL_NONE, SL_A);
      OP_RNIMP: plan_o.st[0] = mk_step(PK_ANDN, SL_A,    SL_NONE, SL_B);
      OP_COPYA: begin
        plan_o.last  = 2'd1;
        plan_o.st[0] = mk_step(PK_NOT, SL_A, SL_NONE, SL_S);
        plan_o.st[1] = mk_step(PK_NOT, SL_S, SL_NONE, SL_D);
      end
      OP_COPYB: begin
        plan_o.last  = 2'd1;
        plan_o.st[0] = mk_step(PK_NOT, SL_B, SL_NONE, SL_S);
        plan_o.st[1] = mk_step(PK_NOT, SL_S, SL_NONE, SL_D);
      end
      OP_AND: begin
        plan_o.last  = 2'd1;
        plan_o.st[0] = mk_step(PK_NAND, SL_A, SL_B,    SL_S);
        plan_o.st[1] = mk_step(PK_NOT,  SL_S, SL_NONE, SL_D);
      end
      OP_OR: begin
        plan_o.last  = 2'd1;
        plan_o.st[0] = mk_step(PK_NOR, SL_A, SL_B,    SL_S);
        plan_o.st[1] = mk_step(PK_NOT, SL_S, SL_NONE, SL_D);
      end
      OP_XNOR: begin
        plan_o.last  = 2'd2;
        plan_o.st[0] = mk_step(PK_NAND, SL_A, SL_B,    SL_S);
        plan_o.st[1] = mk_step(PK_NOR,  SL_A, SL_B,    SL_D);
        plan_o.st[2] = mk_step(PK_ORN,  SL_S, SL_NONE, SL_D);
      end
      default: begin // OP_XOR
        plan_o.last  = 2'd2;
        plan_o.st[0] = mk_step(PK_NOR,  SL_A, SL_B,    SL_S);
        plan_o.st[1] = mk_step(PK_NAND, SL_A, SL_B,    SL_D);
        plan_o.st[2] = mk_step(PK_ANDN, SL_S, SL_NONE, SL_D);
      end
    endcase
  end

  always_comb begin
    rd_a_o  = 1'b0;
    rd_b_o  = 1'b0;
    wr_d_o  = 1'b0;
    use_s_o = 1'b0;
    for (int i = 0; i < MAX_STEPS; i++) begin
      if (i <= int'(plan_o.last)) begin
        if (plan_o.st[i].x == SL_A || plan_o.st[i].y == SL_A) rd_a_o = 1'b1;
        if (plan_o.st[i].x == SL_B || plan_o.st[i].y == SL_B) rd_b_o = 1'b1;
        if (plan_o.st[i].x == SL_S || plan_o.st[i].t == SL_S) use_s_o = 1'b1;
        if (plan_o.st[i].t == SL_D) wr_d_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uop_guard.sv
module uop_guard #(
  parameter int N_CELLS = 16,
  parameter int IW      = 4
) (
  input  logic [IW-1:0] a_i,
  input  logic [IW-1:0] b_i,
  input  logic [IW-1:0] d_i,
  input  logic          rd_a_i,
  input  logic          rd_b_i,
  input  logic          wr_d_i,
  input  logic          use_s_i,
  output logic          err_o
);
  localparam logic [IW-1:0] SCR = IW'(N_CELLS - 1);

  logic scr_hit, dst_hit;

  assign scr_hit = use_s_i && ((rd_a_i && a_i == SCR) || (rd_b_i && b_i == SCR) || d_i == SCR);
  assign dst_hit = wr_d_i && ((rd_a_i && d_i == a_i) || (rd_b_i && d_i == b_i));
  assign err_o   = scr_hit || dst_hit;
endmodule

// File: rtl/uop_cells.sv
module uop_cells #(
  parameter int N_CELLS = 16,
  parameter int IW      = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_en_i,
  input  logic [IW-1:0]      clr_idx_i,
  input  logic               wr_en_i,
  input  logic [IW-1:0]      wr_idx_i,
  input  logic               wr_val_i,
  input  logic [IW-1:0]      rd_idx_i,
  output logic               rd_data_o,
  output logic [N_CELLS-1:0] cells_o
);
  logic [N_CELLS-1:0] cells_q;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cells_q[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IW'(g)) begin
        cells_q[g] <= wr_val_i;
      end else if (clr_en_i && clr_idx_i == IW'(g)) begin
        cells_q[g] <= 1'b0;
      end
    end
  end

  assign rd_data_o = cells_q[rd_idx_i];
  assign cells_o   = cells_q;

  AST_SINGLE_CELL_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cells_q ^ $past(cells_q)) <= 1); // R6
endmodule

// File: rtl/uop_seq.sv
module uop_seq
  import uop_pkg::*;
#(
  parameter int N_CELLS  = 16,
  parameter int IW       = 4,
  parameter int STEP_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [IW-1:0]      a_i,
  input  logic [IW-1:0]      b_i,
  input  logic [IW-1:0]      d_i,
  input  plan_t              plan_i,
  input  logic               bad_i,
  input  logic [N_CELLS-1:0] cells_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               clr_en_o,
  output logic [IW-1:0]      clr_idx_o,
  output logic               wr_en_o,
  output logic [IW-1:0]      wr_idx_o,
  output logic               wr_val_o
);
  localparam int            CW       = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_CYC - 1);
  localparam logic [IW-1:0] SCR      = IW'(N_CELLS - 1);

  logic          busy_q, done_q, err_q;
  plan_t         plan_q;
  logic [IW-1:0] a_q, b_q, d_q;
  logic [SW-1:0] si_q;
  logic [CW-1:0] cnt_q;

  step_t         cur;
  logic [IW-1:0] x_idx, y_idx, t_idx;
  logic          x_v, y_v, t_v, res;
  logic          accept, last_cyc, last_step;

  function automatic logic [IW-1:0] pick(sel_e s);
    case (s)
      SL_A:    return a_q;
      SL_B:    return b_q;
      SL_S:    return SCR;
      default: return d_q;
    endcase
  endfunction

  always_comb begin
    case (si_q)
      2'd0:    cur = plan_q.st[0];
      2'd1:    cur = plan_q.st[1];
      default: cur = plan_q.st[2];
    endcase
    x_idx = pick(cur.x);
    y_idx = pick(cur.y);
    t_idx = pick(cur.t);
    x_v   = cells_i[x_idx];
    y_v   = cells_i[y_idx];
    t_v   = cells_i[t_idx];
    case (cur.kind)
      PK_CLR:  res = 1'b0;
      PK_SET:  res = 1'b1;
      PK_NOT:  res = ~x_v;
      PK_NAND: res = ~(x_v & y_v);
      PK_NOR:  res = ~(x_v | y_v);
      PK_ORN:  res = t_v | ~x_v;
      PK_ANDN: res = t_v & ~x_v;
      default: res = 1'b0;
    endcase
  end

  assign accept    = valid_i && !busy_q;
  assign last_cyc  = cnt_q == CNT_LAST;
  assign last_step = si_q == plan_q.last;

  assign clr_en_o  = busy_q && cnt_q == '0 && presets(cur.kind);
  assign clr_idx_o = t_idx;
  assign wr_en_o   = busy_q && last_cyc;
  assign wr_idx_o  = t_idx;
  assign wr_val_o  = res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      plan_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      d_q    <= '0;
      si_q   <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= accept && bad_i;
      if (accept && !bad_i) begin
        busy_q <= 1'b1;
        plan_q <= plan_i;
        a_q    <= a_i;
        b_q    <= b_i;
        d_q    <= d_i;
        si_q   <= '0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_cyc) begin
          cnt_q <= '0;
          if (last_step) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            si_q <= si_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o)); // R8
  AST_ERR_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o); // R9
  AST_ACCEPT_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !busy_o) |=> (busy_o ^ err_o)); // R7
endmodule

// File: rtl/bool_uop_engine.sv
module bool_uop_engine
  import uop_pkg::*;
#(
  parameter int N_CELLS  = 16,
  parameter int STEP_CYC = 4,
  localparam int IW      = $clog2(N_CELLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [3:0]    cmd_op_i,
  input  logic [IW-1:0] cmd_a_i,
  input  logic [IW-1:0] cmd_b_i,
  input  logic [IW-1:0] cmd_dst_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  input  logic [IW-1:0] rd_idx_i,
  output logic          rd_data_o
);
  plan_t              plan;
  logic               rd_a, rd_b, wr_d, use_s, bad;
  logic               clr_en, wr_en, wr_val;
  logic [IW-1:0]      clr_idx, wr_idx;
  logic [N_CELLS-1:0] cells;

  uop_decoder u_dec (
    .op_i    (cmd_op_i),
    .plan_o  (plan),
    .rd_a_o  (rd_a),
    .rd_b_o  (rd_b),
    .wr_d_o  (wr_d),
    .use_s_o (use_s)
  );

  uop_guard #(.N_CELLS(N_CELLS), .IW(IW)) u_guard (
    .a_i     (cmd_a_i),
    .b_i     (cmd_b_i),
    .d_i     (cmd_dst_i),
    .rd_a_i  (rd_a),
    .rd_b_i  (rd_b),
    .wr_d_i  (wr_d),
    .use_s_i (use_s),
    .err_o   (bad)
  );

  uop_seq #(.N_CELLS(N_CELLS), .IW(IW), .STEP_CYC(STEP_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cmd_valid_i),
    .a_i       (cmd_a_i),
    .b_i       (cmd_b_i),
    .d_i       (cmd_dst_i),
    .plan_i    (plan),
    .bad_i     (bad),
    .cells_i   (cells),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .clr_en_o  (clr_en),
    .clr_idx_o (clr_idx),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_val_o  (wr_val)
  );

  uop_cells #(.N_CELLS(N_CELLS), .IW(IW)) u_cells (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_en_i  (clr_en),
    .clr_idx_i (clr_idx),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_val_i  (wr_val),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .cells_o   (cells)
  );

  assign cmd_ready_o = ~busy_o;

  AST_IDLE_CELLS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(cells)); // R7
  AST_REFUSED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(cells)); // R9
endmodule

// File: tb/sim_bool_uop_engine.sv
`timescale 1ns/1ps
module sim_bool_uop_engine;
  localparam int N   = 16;
  localparam int SC  = 4;
  localparam int IW  = 4;
  localparam int SCR = N - 1;
  localparam int WD  = 100000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid;
  logic [3:0]    cmd_op;
  logic [IW-1:0] cmd_a, cmd_b, cmd_dst, rd_idx;
  logic          ready, busy, done, err, rd_data;

  always #10 clk = ~clk;

  bool_uop_engine #(.N_CELLS(N), .STEP_CYC(SC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(ready),
    .cmd_op_i(cmd_op), .cmd_a_i(cmd_a), .cmd_b_i(cmd_b), .cmd_dst_i(cmd_dst),
    .busy_o(busy), .done_o(done), .err_o(err), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state: value after the most recent rising edge
  bit    m_cells[N];
  bit    m_busy, m_done, m_err;
  int    m_si, m_cnt, m_n;
  int    m_k[3], m_x[3], m_y[3], m_t[3];
  string m_tag = "R2";

  int q_op[$], q_a[$], q_b[$], q_d[$];

  task automatic push(input int op, input int a, input int b, input int d);
    q_op.push_back(op); q_a.push_back(a); q_b.push_back(b); q_d.push_back(d);
  endtask

  function automatic bit reads_a(input int op);
    return op inside {2, 4, 5, 6, 7, 8, 9, 10, 12, 13, 14, 15};
  endfunction
  function automatic bit reads_b(input int op);
    return op inside {3, 4, 5, 6, 7, 8, 9, 11, 12, 13, 14, 15};
  endfunction
  function automatic bit refused(input int op, input int a, input int b, input int d);
    bit wd;
    wd = !(op inside {6, 7, 8, 9});
    return (op >= 10 && ((reads_a(op) && a == SCR) || (reads_b(op) && b == SCR) || d == SCR)) ||
           (wd && ((reads_a(op) && d == a) || (reads_b(op) && d == b)));
  endfunction

  // kinds: 0 clear, 1 set, 2 not, 3 nand, 4 nor, 5 or-not (no clear), 6 and-not (no clear)
  task automatic st(input int i, input int k, input int x, input int y, input int t);
    m_k[i] = k; m_x[i] = x; m_y[i] = y; m_t[i] = t;
  endtask

  task automatic build(input int op, input int a, input int b, input int d);
    m_n = 1;
    case (op)
      0:  st(0, 0, -1, -1, d);
      1:  st(0, 1, -1, -1, d);
      2:  st(0, 2, a, -1, d);
      3:  st(0, 2, b, -1, d);
      4:  st(0, 3, a, b, d);
      5:  st(0, 4, a, b, d);
      6:  st(0, 5, a, -1, b);
      7:  st(0, 6, b, -1, a);
      8:  st(0, 5, b, -1, a);
      9:  st(0, 6, a, -1, b);
      10: begin m_n = 2; st(0, 2, a, -1, SCR); st(1, 2, SCR, -1, d); end
      11: begin m_n = 2; st(0, 2, b, -1, SCR); st(1, 2, SCR, -1, d); end
      12: begin m_n = 2; st(0, 3, a, b, SCR);  st(1, 2, SCR, -1, d); end
      13: begin m_n = 2; st(0, 4, a, b, SCR);  st(1, 2, SCR, -1, d); end
      14: begin m_n = 3; st(0, 3, a, b, SCR); st(1, 4, a, b, d); st(2, 5, SCR, -1, d); end
      default: begin m_n = 3; st(0, 4, a, b, SCR); st(1, 3, a, b, d); st(2, 6, SCR, -1, d); end
    endcase
  endtask

  task automatic advance(input bit v, input int op, input int a, input int b, input int d);
    bit xv, yv, tv, res;
    int k, t;
    m_done = 0;
    m_err  = 0;
    if (m_busy) begin
      k  = m_k[m_si];
      t  = m_t[m_si];
      xv = (m_x[m_si] >= 0) ? m_cells[m_x[m_si]] : 1'b0;
      yv = (m_y[m_si] >= 0) ? m_cells[m_y[m_si]] : 1'b0;
      tv = m_cells[t];
      case (k)
        0: res = 0;
        1: res = 1;
        2: res = !xv;
        3: res = !(xv && yv);
        4: res = !(xv || yv);
        5: res = tv || !xv;
        default: res = tv && !xv;
      endcase
      if (m_cnt == 0 && k <= 4) m_cells[t] = 0;
      if (m_cnt == SC - 1) begin
        m_cells[t] = res;
        m_cnt = 0;
        if (m_si == m_n - 1) begin
          m_busy = 0;
          m_done = 1;
        end else begin
          m_si++;
        end
      end else begin
        m_cnt++;
      end
    end else if (v) begin
      if (refused(op, a, b, d)) begin
        m_err = 1;
        m_tag = "R9";
      end else begin
        build(op, a, b, d);
        m_busy = 1;
        m_si   = 0;
        m_cnt  = 0;
        m_tag  = (op < 6) ? "R3" : (op < 10) ? "R5" : "R4";
      end
    end
  endtask

  initial begin
    int qi, gap, cyc, idle;
    cmd_valid = 0; cmd_op = '0; cmd_a = '0; cmd_b = '0; cmd_dst = '0; rd_idx = '0;

    // loading and a few plain constants
    push(1, 0, 0, 0); push(1, 0, 0, 7); push(0, 0, 0, 7); push(1, 0, 0, SCR);
    for (int op = 0; op < 16; op++) begin
      for (int ab = 0; ab < 4; ab++) begin
        push((ab >> 1) & 1, 0, 0, 3);
        push(ab & 1, 0, 0, 4);
        push(op, 3, 4, 5);
      end
    end
    // implication with both sources on one cell, and a different destination
    push(0, 0, 0, 6); push(6, 6, 6, 9);
    push(1, 0, 0, 8); push(15, 8, 6, 11); push(14, 8, 6, 12);
    // refused commands (R9)
    push(4, 3, 4, 3); push(3, 0, 4, 4); push(12, SCR, 4, 5);
    push(15, 3, 4, SCR); push(11, 3, SCR, 5); push(13, 3, SCR, 5); push(2, 5, 0, 5);
    // single-step op may read the scratch cell
    push(2, SCR, 0, 10); push(10, 3, 0, 2);

    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1", "ready in reset", ready, 1);
    chk(busy  == 1'b0, "R1", "busy in reset", busy, 0);
    chk(done  == 1'b0, "R1", "done in reset", done, 0);
    chk(err   == 1'b0, "R1", "err in reset", err, 0);
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i);
      #1;
      chk(rd_data == 1'b0, "R1", "cell after reset", rd_data, 0);
    end
    for (int i = 0; i < N; i++) m_cells[i] = 0;
    m_busy = 0; m_done = 0; m_err = 0; m_si = 0; m_cnt = 0;
    rst_ni = 1'b1;

    qi = 0; gap = 0; cyc = 0; idle = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      chk(ready == !m_busy, "R7", "ready", ready, !m_busy);
      chk(busy == m_busy, "R7", "busy", busy, m_busy);
      chk(done == m_done, "R8", "done", done, m_done);
      chk(err == m_err, "R9", "err", err, m_err);
      chk(rd_data == m_cells[rd_idx], m_busy ? "R6" : m_tag, $sformatf("cell %0d", rd_idx),
          rd_data, m_cells[rd_idx]); // R2 read path on every cycle
      if (cyc > WD) begin
        chk(1'b0, "WDOG", "watchdog expired", cyc, WD);
        break;
      end
      cmd_valid = 0;
      rd_idx = IW'(cyc % N);
      if (!m_busy) begin
        if (gap > 0) begin
          gap--;
        end else if (qi < q_op.size()) begin
          cmd_op = 4'(q_op[qi]); cmd_a = IW'(q_a[qi]); cmd_b = IW'(q_b[qi]); cmd_dst = IW'(q_d[qi]);
          cmd_valid = 1;
          qi++;
          gap = (qi % 3 == 0) ? 1 : 0;
        end
      end else if (cyc % 5 == 0) begin
        // offered while busy: must be ignored (R7)
        cmd_op = 4'(cyc % 16); cmd_a = IW'(cyc % 7); cmd_b = IW'(cyc % 5); cmd_dst = IW'(cyc % N);
        cmd_valid = 1;
      end
      advance(cmd_valid, int'(cmd_op), int'(cmd_a), int'(cmd_b), int'(cmd_dst));
      if (qi == q_op.size() && !m_busy) idle++;
      if (idle > N + 2) break;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule